// File: doc/BRIEF.md
# Sampling ADC Clock Sequencer

This block drives a serial successive-approximation converter from a single system clock. A free-running binary counter supplies a periodic sample command whose rate is picked by a select input. In the default setup, a 12.288 MHz system clock gives 96 kHz when the counter is divided by 128 and 48 kHz when it is divided by 256. A second divider produces the converter clock. The converter's busy line keeps that divider in reset while the input is being acquired, so the converter sees no clock edges until acquisition ends.

The block counts the rising edges of the converter clock. When the seventeenth rising edge of a conversion occurs, it emits a one-cycle done pulse. It also times each conversion, from the sample command rising to that seventeenth edge, against a maximum window derived from the system-clock frequency. If a conversion overruns the window, the block sets a flag that stays set. The sample command changes state only at moments that are safe for the converter clock. Data capture and all analog behaviour are handled elsewhere.

Top module: `adc_clk_seq`

## Requirements
- R1: With `en` high and `busy` held low, `sample` follows a free-running counter tap one clock later. The tap is high for the upper half of each period. The period is 128 cycles when `rate_sel`=0 and 256 cycles when `rate_sel`=1.
- R2: At every edge where `busy` is low, `conv_clk` is forced low and the divider is cleared. After `busy` goes high, the first `conv_clk` rise appears on the second clock edge that samples `busy` high.
- R3: While `busy` stays high, `conv_clk` repeats every `CONV_DIV` cycles. It is high for `CONV_DIV/2` cycles and low for the rest, so the low phase is never shorter than the high phase. A fall of `conv_clk` is always followed by at least one further low cycle.
- R4: `conv_done` is a one-cycle pulse. It is set by the same edge that produces the seventeenth `conv_clk` rise after the latest `sample` rise. It is never set earlier than that edge.
- R5: A `sample` rise clears the edge count. A conversion that was cut short therefore adds nothing to the next conversion, and rises beyond the seventeenth give no further pulse.
- R6: `sample` changes only at an edge where the divider was held in reset, or where `conv_clk` has just risen while `busy` is high. A fall of `sample` never coincides with a `conv_clk` edge.
- R7: `conv_timeout` is set when the seventeenth rise comes more than TIMEOUT cycles after the `sample` rise. TIMEOUT is (SYS_CLK_HZ/1000)*MAX_CONV_US/1000, which is 12288 by default. A rise arriving exactly TIMEOUT cycles after the `sample` rise leaves the flag clear. Once set, the flag stays set until reset.
- R8: The conversion timer stops after a conversion completes. Any amount of idle time between conversions never sets `conv_timeout`.
- R9: While `en` is low, the rate counter holds its value. `sample` drops at the next permitted edge and does not rise.
- R10: Synchronous reset `rst` clears all counters and flags and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables the sample-rate counter and the sample command |
| rate_sel | input | 1 | 0: divide by 128; 1: divide by 256 |
| busy | input | 1 | Converter busy; low during acquisition |
| sample | output | 1 | Sample command to the converter |
| conv_clk | output | 1 | Gated converter clock |
| conv_done | output | 1 | One-cycle pulse at the seventeenth converter-clock rise |
| conv_timeout | output | 1 | Sticky flag for a conversion-time overrun |

## Verification
The assertions check, on every cycle, the rules that hold locally: the clock stays quiet while `busy` is low, the minimum low phase, that `sample` moves only at permitted edges and never falls together with a clock edge, the single-cycle done pulse, the sticky timeout, and the frozen counter while disabled. Only the bench scenarios can show the absolute timing. These include the two sample periods, the exact cycle of the first and the seventeenth clock rise after `busy` goes high, and the count restarting after an aborted conversion. They also include the timeout landing on exactly the right side of the window boundary and long idle gaps leaving the flag clear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Cycles allowed between a sample rise and the final converter-clock rise.
  function automatic int unsigned conv_window_cycles(input int unsigned hz,
                                                     input int unsigned max_us);
    return (hz / 1000) * max_us / 1000;
  endfunction

  // High portion of the converter clock, in system cycles.
  function automatic int unsigned clk_high_cycles(input int unsigned div);
    return div / 2;
  endfunction

  // Low portion of the converter clock; never shorter than the high portion.
  function automatic int unsigned clk_low_cycles(input int unsigned div);
    return div - (div / 2);
  endfunction

  // Counter bit whose toggling gives a period of 2**log2_div cycles.
  function automatic int unsigned tap_bit(input int unsigned log2_div);
    return log2_div - 1;
  endfunction

endpackage

// File: rtl/adc_rate_gen.sv
module adc_rate_gen #(
  parameter int unsigned FAST_LOG2 = 7,
  parameter int unsigned SLOW_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rate_sel,
  output logic tap
);
  import adc_seq_pkg::*;

  localparam int unsigned CW       = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam int unsigned FAST_BIT = tap_bit(FAST_LOG2);
  localparam int unsigned SLOW_BIT = tap_bit(SLOW_LOG2);

  logic [CW-1:0] rate_cnt;

  always_ff @(posedge clk) begin
    if (rst)     rate_cnt <= '0;
    else if (en) rate_cnt <= rate_cnt + 1'b1;
  end

  assign tap = rate_sel ? rate_cnt[SLOW_BIT] : rate_cnt[FAST_BIT];

  // R9: counter holds while disabled
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rate_cnt));

endmodule

// File: rtl/adc_conv_div.sv
module adc_conv_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic conv_clk,
  output logic rise_evt,
  output logic sample_ok
);
  import adc_seq_pkg::*;

  localparam int unsigned CNTW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned LOW_CNT = clk_low_cycles(DIV);

  logic [CNTW-1:0] div_cnt;
  logic [CNTW-1:0] div_nxt;
  logic            held;

  always_comb begin
    if (!busy)                          div_nxt = '0;
    else if (div_cnt == CNTW'(DIV - 1)) div_nxt = '0;
    else                                div_nxt = div_cnt + 1'b1;
  end

  // Edge at which the converter clock goes high.
  assign rise_evt  = busy && (div_nxt == CNTW'(LOW_CNT));
  // Safe moments for the sample command: divider in reset, or rise just made.
  assign sample_ok = held || (busy && (div_cnt == CNTW'(LOW_CNT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      conv_clk <= 1'b0;
      held     <= 1'b1;
    end else begin
      div_cnt  <= div_nxt;
      conv_clk <= busy && (div_nxt >= CNTW'(LOW_CNT));
      held     <= !busy;
    end
  end

  // R2: no converter clock while acquiring
  a_r2_held_low: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !conv_clk);

  // R3: the low phase spans more than one cycle after every fall
  a_r3_low_min: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_clk) |=> !conv_clk);

  // R3: the high phase is not a single-cycle spike while busy stays high
  a_r3_high_min: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_clk) && busy) |=> conv_clk);

endmodule

// File: rtl/adc_conv_mon.sv
module adc_conv_mon #(
  parameter int unsigned EDGES  = 17,
  parameter int unsigned WINDOW = 12288
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_rise,
  input  logic rise_evt,
  output logic done,
  output logic timeout
);
  localparam int unsigned EW = $clog2(EDGES + 1);
  localparam int unsigned TW = $clog2(WINDOW + 1);

  logic [EW-1:0] edge_cnt;
  logic [TW-1:0] timer;
  logic          in_conv;
  logic          finish;

  assign finish = rise_evt && (edge_cnt == EW'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      timer    <= '0;
      in_conv  <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= finish;

      if (sample_rise)
        edge_cnt <= '0;
      else if (rise_evt && (edge_cnt != EW'(EDGES)))
        edge_cnt <= edge_cnt + 1'b1;

      if (sample_rise) begin
        in_conv <= 1'b1;
        timer   <= '0;
      end else if (in_conv) begin
        if (finish) in_conv <= 1'b0;
        if (timer != TW'(WINDOW)) timer <= timer + 1'b1;
        if (!finish && (timer == TW'(WINDOW - 1))) timeout <= 1'b1;
      end
    end
  end

  // R4: the done pulse lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: edge count never passes the burst length
  a_r5_count_cap: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= EW'(EDGES));

  // R7: timeout is sticky
  a_r7_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout |=> timeout);

  // R8: timer idle outside a conversion
  a_r8_timer_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_conv && !sample_rise) |=> $stable(timer));

endmodule

// File: rtl/adc_clk_seq.sv
module adc_clk_seq #(
  parameter int unsigned SYS_CLK_HZ  = 12_288_000,
  parameter int unsigned MAX_CONV_US = 1000,
  parameter int unsigned CONV_DIV    = 4,
  parameter int unsigned CONV_EDGES  = 17,
  parameter int unsigned FAST_LOG2   = 7,
  parameter int unsigned SLOW_LOG2   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rate_sel,
  input  logic busy,
  output logic sample,
  output logic conv_clk,
  output logic conv_done,
  output logic conv_timeout
);
  import adc_seq_pkg::*;

  localparam int unsigned WINDOW = conv_window_cycles(SYS_CLK_HZ, MAX_CONV_US);

  logic tap;
  logic rise_evt;
  logic sample_ok;
  logic sample_nxt;
  logic sample_rise;

  adc_rate_gen #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_rate (
    .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel), .tap(tap)
  );

  adc_conv_div #(.DIV(CONV_DIV)) u_div (
    .clk(clk), .rst(rst), .busy(busy),
    .conv_clk(conv_clk), .rise_evt(rise_evt), .sample_ok(sample_ok)
  );

  assign sample_nxt  = sample_ok ? (en && tap) : sample;
  assign sample_rise = sample_nxt && !sample;

  always_ff @(posedge clk) begin
    if (rst) sample <= 1'b0;
    else     sample <= sample_nxt;
  end

  adc_conv_mon #(.EDGES(CONV_EDGES), .WINDOW(WINDOW)) u_mon (
    .clk(clk), .rst(rst), .sample_rise(sample_rise), .rise_evt(rise_evt),
    .done(conv_done), .timeout(conv_timeout)
  );

  // R6: sample moves only at permitted edges
  a_r6_move_ok: assert property (@(posedge clk) disable iff (rst)
    (sample != $past(sample)) |-> $past(sample_ok));

  // R6: falling sample never lines up with a converter-clock edge
  a_r6_fall_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(sample) |-> $stable(conv_clk));

  // R9: no new sample rise while disabled
  a_r9_no_rise: assert property (@(posedge clk) disable iff (rst)
    (!en && !sample) |=> !sample);

endmodule

// File: tb/tb_adc_clk_seq.sv
module tb_adc_clk_seq;
  localparam longint SYS_HZ   = 12288000;
  localparam longint MAX_US   = 1000;
  localparam int     DIV      = 4;
  localparam int     EDGES    = 17;
  localparam int     WIN      = int'(SYS_HZ * MAX_US / 1000000);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic rate_sel = 1'b0;
  logic busy = 1'b0;
  logic sample, conv_clk, conv_done, conv_timeout;

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 1'b0;
  bit exp_tmo = 1'b0;

  always #4 clk = ~clk;

  adc_clk_seq dut (
    .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel), .busy(busy),
    .sample(sample), .conv_clk(conv_clk), .conv_done(conv_done),
    .conv_timeout(conv_timeout)
  );

  function automatic int period_of(input bit sel);
    return sel ? 256 : 128;
  endfunction
  function automatic bit tap_of(input int cnt, input bit sel);
    return (cnt % period_of(sel)) >= (period_of(sel) / 2);
  endfunction
  function automatic int hi_len();  return DIV / 2;                endfunction
  function automatic int lo_len();  return DIV - DIV / 2;          endfunction
  function automatic int first_rise(); return lo_len();            endfunction
  function automatic int last_rise();  return lo_len() + (EDGES - 1) * DIV; endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model of the sample command while the divider is idle.
  int m_cnt = 0;
  bit m_exp = 1'b0;
  bit b1 = 1'b1, b2 = 1'b1;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_exp <= 1'b0; b1 <= 1'b1; b2 <= 1'b1;
    end else begin
      m_exp <= en ? tap_of(m_cnt, rate_sel) : 1'b0;
      if (en) m_cnt <= m_cnt + 1;
      b1 <= busy; b2 <= b1;
    end
  end

  always @(negedge clk) begin
    if (armed && !rst && !b1 && !b2)
      chk(sample == m_exp, "R1/R9 sample vs counter model", sample, m_exp);
  end

  task automatic do_reset();
    armed = 1'b0;
    @(negedge clk); rst = 1'b1; busy = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample == 0, "R10 sample after reset", sample, 0);
    chk(conv_clk == 0, "R10 conv_clk after reset", conv_clk, 0);
    chk(conv_done == 0, "R10 done after reset", conv_done, 0);
    chk(conv_timeout == 0, "R10 timeout after reset", conv_timeout, 0);
    rst = 1'b0; exp_tmo = 1'b0;
    @(negedge clk); armed = 1'b1;
  endtask

  task automatic measure_period(input bit sel);
    bit ps;
    int gap;
    rate_sel = sel;
    repeat (300) @(negedge clk);
    ps = sample;
    forever begin @(negedge clk); if (sample && !ps) break; ps = sample; end
    gap = 0; ps = sample;
    forever begin @(negedge clk); gap++; if (sample && !ps) break; ps = sample; end
    chk(gap == period_of(sel), "R1 sample period", gap, period_of(sel));
  endtask

  task automatic convert(input int acq, input int abort_at, input bit drop_en);
    bit ps, pc, acq_clk;
    int k, rises, hi, lo, guard;
    ps = sample;
    forever begin @(negedge clk); if (sample && !ps) break; ps = sample; end
    k = 0;
    if (drop_en) en = 1'b0;
    acq_clk = 1'b0;
    for (int i = 0; i < acq; i++) begin
      @(negedge clk); k++;
      if (conv_clk) acq_clk = 1'b1;
    end
    chk(!acq_clk, "R2 no conv_clk during acquisition", acq_clk, 0);
    busy = 1'b1;
    pc = 1'b0; rises = 0; hi = 0; lo = 0; guard = 0;
    forever begin
      @(negedge clk); k++; guard++;
      if (conv_clk && !pc) begin
        rises++;
        if (rises == 1)
          chk(k - acq == first_rise(), "R2 first rise delay", k - acq, first_rise());
        else if (rises == 2 || rises == EDGES)
          chk(lo == lo_len(), "R3 low phase length", lo, lo_len());
        hi = 1;
        if (rises == EDGES) begin
          chk(conv_done == 1, "R4 done at last rise", conv_done, 1);
          chk(k - acq == last_rise(), "R4 last rise timing", k - acq, last_rise());
          if (k > WIN) exp_tmo = 1'b1;
          chk(conv_timeout == exp_tmo, "R7 timeout at end", conv_timeout, exp_tmo);
          busy = 1'b0;
          @(negedge clk);
          chk(conv_done == 0, "R4 done lasts one cycle", conv_done, 1'b0);
          break;
        end
        if (rises == abort_at) begin
          chk(conv_done == 0, "R5 no done on short burst", conv_done, 0);
          busy = 1'b0;
          break;
        end
      end else if (!conv_clk && pc) begin
        if (rises == 1)
          chk(hi == hi_len(), "R3 high phase length", hi, hi_len());
        lo = 1;
      end else if (conv_clk) hi++;
      else lo++;
      if (conv_done && rises < EDGES) chk(0, "R4 early done", rises, EDGES);
      pc = conv_clk;
      if (guard > 2000) begin chk(0, "R4 burst never completed", rises, EDGES); busy = 1'b0; break; end
    end
    if (drop_en) en = 1'b1;
  endtask

  task automatic run_all();
    void'($urandom(32'd20240611));
    do_reset();
    en = 1'b1;
    measure_period(1'b0);
    measure_period(1'b1);
    measure_period(1'b0);
    en = 1'b0;                      // R9: frozen counter, sample low
    repeat (300) @(negedge clk);
    chk(sample == 0, "R9 sample low while disabled", sample, 0);
    en = 1'b1;
    for (int n = 0; n < 8; n++) begin
      rate_sel = $urandom % 2;
      convert(3 + int'($urandom % 38), 0, 1'b0);
    end
    chk(conv_timeout == 0, "R7 no timeout on short conversions", conv_timeout, 0);
    rate_sel = 1'b0;
    convert(10, 10, 1'b0);          // R5: aborted burst
    convert(12, 0, 1'b0);           // R5: fresh count of 17
    convert(WIN - last_rise(), 0, 1'b1);   // R7: exactly at the limit
    chk(conv_timeout == 0, "R7 limit not exceeded", conv_timeout, 0);
    en = 1'b0;
    repeat (WIN + 700) @(negedge clk);     // R8: long idle
    chk(conv_timeout == 0, "R8 idle gap", conv_timeout, 0);
    en = 1'b1;
    convert(WIN - last_rise() + 1, 0, 1'b1); // R7: one past the limit
    chk(conv_timeout == 1, "R7 overrun flagged", conv_timeout, 1);
    convert(20, 0, 1'b0);
    chk(conv_timeout == 1, "R7 timeout sticky", conv_timeout, 1);
    do_reset();                     // R10
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule